// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register-level front end of a hardware random number source. Software reaches it through six 32-bit registers on a single-cycle read/write bus. Through them it starts a self test or a seed generation, watches status and error state, and pulls random words out of a 16-entry output queue. Completions and errors raise one interrupt line. The done part and the error part of that line are masked separately. The clear commands act differently depending on whether an error is pending.

The real entropy source and generator core are modelled by a stand-in. The stand-in has a fixed operation latency and an error code input that the test environment drives. Each generated 160-bit block comes from a 32-bit shift register and goes into the queue as five 32-bit entries. A reseed counter counts completed blocks. When automatic seeding is enabled, a fresh seed is started without software once the configured number of blocks has been produced.

Top module: `rng_ctl_top`

## Requirements
- R1: After reset:
  - version (offset 0x00) reads {type code in 31:28, zero, major in 15:8, minor in 7:0}, which is 0x20000103 by default;
  - control (0x08), status (0x0C) and error (0x10) read 0;
  - `irq` is low.
- R2: Command (0x04) bits are one-cycle pulses and the register always reads 0.
- R3: Writing command bit 0 starts a self test. After the operation latency, status bit 4 (self test done) is set.
- R4: Writing command bit 1 starts a seed generation, which sets status bit 5 (seed done) on completion. After a successful seed, the generator fills the queue in groups of five entries. A group is started only when at least five entries are free, so an idle queue settles at 15 and can reach 16 after reads. The level never exceeds 16.
- R5: Status bits 12:8 hold the queue level. Reads of 0x14 pop entries in generation order. With shift register state x starting at 0x1ACEB00C, each entry is the new state {x[30:0], x[31]^x[21]^x[1]^x[0]}.
- R6: Reading 0x14 with an empty queue returns 0, and the level stays 0.
- R7: No entry is generated before a successful seed. A seed that completes with an error stops further generation.
- R8: If `inj_err_code` is nonzero when an operation completes, that value is placed in the error register and status bit 16 is set. The done bit of that operation is still set.
- R9: Command bit 4 clears the done bits only while no error is pending. Command bit 5 clears the error register and the done bits only while an error is pending. When no error is pending, command bit 5 has no effect.
- R10: `irq` = ((status bit 4 or 5) and not control bit 5) or (error pending and not control bit 6).
- R11: A start command written while an operation is running is ignored.
- R12: With control bit 4 set, a seed generation starts on its own once RESEED_BLOCKS blocks have completed since the last seed. With control bit 4 clear, none starts.
- R13: After an error has been cleared, a new seed command is accepted and can complete without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access |
| inj_err_code | input | 4 | Error code recorded when an operation completes (0 = none) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check properties that must hold on every cycle:
- the queue level stays within its depth and moves by at most one entry per cycle;
- an empty read returns zero, and command reads return zero;
- no entry is pushed before any seed;
- the clear-interrupt command leaves a pending error and the done bits untouched;
- a start written during a running operation does not change it.

Only the bench scenarios can show the following:
- the exact random word order and the group-of-five fill thresholds (15, then 16);
- the split between the done mask and the error mask on `irq`;
- retrying a seed after a statistical error;
- automatic reseeding that appears without any command after the block count.

// File: rtl/rng_ctl_pkg.sv
// Package: shared register offsets, bit positions and operation type
// for the random number generator control front end.
package rng_ctl_pkg;
    localparam int OFF_VER  = 'h00;
    localparam int OFF_CMD  = 'h04;
    localparam int OFF_CTRL = 'h08;
    localparam int OFF_STAT = 'h0C;
    localparam int OFF_ERR  = 'h10;
    localparam int OFF_FIFO = 'h14;

    localparam int CMD_TEST    = 0;
    localparam int CMD_SEED    = 1;
    localparam int CMD_CLR_INT = 4;
    localparam int CMD_CLR_ERR = 5;

    localparam int CTL_AUTO   = 4;
    localparam int CTL_MDONE  = 5;
    localparam int CTL_MERR   = 6;

    localparam int ST_TDONE = 4;
    localparam int ST_SDONE = 5;
    localparam int ST_LVL   = 8;
    localparam int ST_ERR   = 16;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_TEST = 2'd1,
        OP_SEED = 2'd2
    } op_t;
endpackage

// File: rtl/rng_ctl_fifo.sv
// Module: output queue of random words.
// Assumes the producer never pushes into a full queue; such a push is
// dropped anyway. A pop of an empty queue is ignored and dout reads 0.
module rng_ctl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    assign do_push = push && (level != LVL_W'(DEPTH));
    assign do_pop  = pop && (level != '0);
    assign dout    = (level == '0) ? '0 : mem[rd_ptr];

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rng_ctl_gen.sv
// Module: stand-in generator core. On start it emits one block of
// BEATS words, one per cycle, each the next state of a 32-bit shift
// register with taps 32,22,2,1. Assumes start only while idle.
module rng_ctl_gen #(
    parameter int          BEATS     = 5,
    parameter logic [31:0] LFSR_INIT = 32'h1ACE_B00C,
    localparam int BEAT_W = $clog2(BEATS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        push,
    output logic [31:0] data,
    output logic        emitting,
    output logic        blk_done
);
    logic [31:0]       lfsr;
    logic [BEAT_W-1:0] beat;

    assign data     = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    assign push     = emitting;
    assign blk_done = emitting && (beat == BEAT_W'(BEATS - 1));

    // Beat sequencing and shift register advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr     <= LFSR_INIT;
            beat     <= '0;
            emitting <= 1'b0;
        end else if (emitting) begin
            lfsr <= data;
            beat <= beat + 1'b1;
            if (blk_done) emitting <= 1'b0;
        end else if (start) begin
            beat     <= '0;
            emitting <= 1'b1;
        end
    end
endmodule

// File: rtl/rng_ctl_seq.sv
// Module: operation sequencer. Runs self test and seed operations of
// fixed latency, holds done and error flags, applies the two clear
// commands, and triggers automatic reseeding from a block counter.
// Assumes command inputs are single-cycle pulses.
module rng_ctl_seq #(
    parameter int OP_LAT        = 8,
    parameter int RESEED_BLOCKS = 1 << 20,
    localparam int LAT_W = $clog2(OP_LAT + 1),
    localparam int CNT_W = $clog2(RESEED_BLOCKS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_test,
    input  logic                cmd_seed,
    input  logic                clr_int,
    input  logic                clr_err,
    input  logic                auto_en,
    input  logic                blk_done,
    input  logic [3:0]          inj_code,
    output logic                busy,
    output rng_ctl_pkg::op_t    op_kind,
    output logic                st_done,
    output logic                seed_done,
    output logic [3:0]          err_val,
    output logic                seed_valid
);
    import rng_ctl_pkg::*;

    logic [LAT_W-1:0] lat_cnt;
    logic [CNT_W-1:0] blk_cnt;
    logic             fin;
    logic             auto_go;
    logic             err_pend;
    logic             flag_clr;

    assign busy     = (op_kind != OP_NONE);
    assign fin      = busy && (lat_cnt == '0);
    assign err_pend = (err_val != 4'd0);
    assign auto_go  = auto_en && (blk_cnt >= CNT_W'(RESEED_BLOCKS));
    assign flag_clr = (clr_int && !err_pend) || (clr_err && err_pend);

    // Operation start, latency countdown and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind <= OP_NONE;
            lat_cnt <= '0;
        end else if (busy) begin
            if (fin) op_kind <= OP_NONE;
            else     lat_cnt <= lat_cnt - 1'b1;
        end else if (cmd_test) begin
            op_kind <= OP_TEST;
            lat_cnt <= LAT_W'(OP_LAT - 1);
        end else if (cmd_seed || auto_go) begin
            op_kind <= OP_SEED;
            lat_cnt <= LAT_W'(OP_LAT - 1);
        end
    end

    // Done flags: completion wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done   <= 1'b0;
            seed_done <= 1'b0;
        end else begin
            if (fin && op_kind == OP_TEST) st_done <= 1'b1;
            else if (flag_clr)             st_done <= 1'b0;
            if (fin && op_kind == OP_SEED) seed_done <= 1'b1;
            else if (flag_clr)             seed_done <= 1'b0;
        end
    end

    // Error register and seed validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_val    <= 4'd0;
            seed_valid <= 1'b0;
        end else begin
            if (fin && inj_code != 4'd0)  err_val <= inj_code;
            else if (clr_err && err_pend) err_val <= 4'd0;
            if (fin && op_kind == OP_SEED) seed_valid <= (inj_code == 4'd0);
        end
    end

    // Saturating count of completed blocks since the last seed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
        end else if (fin && op_kind == OP_SEED) begin
            blk_cnt <= '0;
        end else if (blk_done && blk_cnt < CNT_W'(RESEED_BLOCKS)) begin
            blk_cnt <= blk_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rng_ctl_top.sv
// Module: register front end of the random number generator. Decodes
// single-cycle bus accesses, holds the control register, builds the
// read mux and interrupt, and gates block generation on queue room.
// Assumes a read pops the queue at the clock edge that ends the access.
module rng_ctl_top #(
    parameter int          ADDR_W        = 5,
    parameter int          DEPTH         = 16,
    parameter int          BEATS         = 5,
    parameter int          OP_LAT        = 8,
    parameter int          RESEED_BLOCKS = 1 << 20,
    parameter logic [3:0]  VER_TYPE      = 4'h2,
    parameter logic [7:0]  VER_MAJ       = 8'h01,
    parameter logic [7:0]  VER_MIN       = 8'h03,
    parameter logic [31:0] LFSR_INIT     = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        inj_err_code,
    output logic              irq
);
    import rng_ctl_pkg::*;

    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             wr_cmd;
    logic             wr_ctrl;
    logic             rd_fifo;
    logic [2:0]       ctrl_q;
    logic             busy;
    op_t              op_kind;
    logic             st_done;
    logic             seed_done;
    logic [3:0]       err_val;
    logic             seed_valid;
    logic             gen_push;
    logic [31:0]      gen_data;
    logic             emitting;
    logic             blk_done;
    logic             blk_start;
    logic [31:0]      fifo_dout;
    logic [LVL_W-1:0] fifo_level;
    logic [31:0]      stat_word;

    assign wr_cmd  = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_CMD));
    assign wr_ctrl = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
    assign rd_fifo = bus_en && !bus_we && (bus_addr == ADDR_W'(OFF_FIFO));

    // Control register: automatic seeding enable and the two masks.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 3'b000;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTL_MERR:CTL_AUTO];
    end

    // Start a block only with a valid seed, no operation and room for all beats.
    assign blk_start = seed_valid && !busy && !emitting &&
                       (fifo_level <= LVL_W'(DEPTH - BEATS));

    rng_ctl_seq #(
        .OP_LAT       (OP_LAT),
        .RESEED_BLOCKS(RESEED_BLOCKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_test  (wr_cmd && bus_wdata[CMD_TEST]),
        .cmd_seed  (wr_cmd && bus_wdata[CMD_SEED]),
        .clr_int   (wr_cmd && bus_wdata[CMD_CLR_INT]),
        .clr_err   (wr_cmd && bus_wdata[CMD_CLR_ERR]),
        .auto_en   (ctrl_q[CTL_AUTO - CTL_AUTO]),
        .blk_done  (blk_done),
        .inj_code  (inj_err_code),
        .busy      (busy),
        .op_kind   (op_kind),
        .st_done   (st_done),
        .seed_done (seed_done),
        .err_val   (err_val),
        .seed_valid(seed_valid)
    );

    rng_ctl_gen #(
        .BEATS    (BEATS),
        .LFSR_INIT(LFSR_INIT)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (blk_start),
        .push    (gen_push),
        .data    (gen_data),
        .emitting(emitting),
        .blk_done(blk_done)
    );

    rng_ctl_fifo #(
        .W    (32),
        .DEPTH(DEPTH)
    ) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (gen_push),
        .din  (gen_data),
        .pop  (rd_fifo),
        .dout (fifo_dout),
        .level(fifo_level)
    );

    // Status word assembly.
    always_comb begin
        stat_word = '0;
        stat_word[ST_TDONE] = st_done;
        stat_word[ST_SDONE] = seed_done;
        stat_word[ST_LVL +: LVL_W] = fifo_level;
        stat_word[ST_ERR] = (err_val != 4'd0);
    end

    // Read data mux; command register always reads zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            case (bus_addr)
                ADDR_W'(OFF_VER):  bus_rdata = {VER_TYPE, 12'h000, VER_MAJ, VER_MIN};
                ADDR_W'(OFF_CTRL): bus_rdata = {25'd0, ctrl_q, 4'd0};
                ADDR_W'(OFF_STAT): bus_rdata = stat_word;
                ADDR_W'(OFF_ERR):  bus_rdata = {28'd0, err_val};
                ADDR_W'(OFF_FIFO): bus_rdata = fifo_dout;
                default:           bus_rdata = '0;
            endcase
        end
    end

    // Interrupt: done events and pending error, each under its own mask.
    assign irq = ((st_done || seed_done) && !ctrl_q[CTL_MDONE - CTL_AUTO]) ||
                 ((err_val != 4'd0) && !ctrl_q[CTL_MERR - CTL_AUTO]);
endmodule

// File: rtl/rng_ctl_chk.sv
// Module: property checker for rng_ctl_top, attached by bind below.
module rng_ctl_chk #(
    parameter int ADDR_W = 5,
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [LVL_W-1:0]  level,
    input logic              push,
    input logic              seed_valid,
    input logic              busy,
    input logic [1:0]        op_kind,
    input logic              st_done,
    input logic              seed_done,
    input logic [3:0]        err_val
);
    import rng_ctl_pkg::*;

    logic ever_seeded;
    logic cmd_wr;

    assign cmd_wr = bus_en && bus_we && (bus_addr == ADDR_W'(OFF_CMD));

    // Remembers that a valid seed has existed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)          ever_seeded <= 1'b0;
        else if (seed_valid) ever_seeded <= 1'b1;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    p_level_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (level == $past(level)) || (level == $past(level) + 1'b1) ||
                 (level == $past(level) - 1'b1));

    p_cmd_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'(OFF_CMD)) |-> (bus_rdata == 32'd0));

    p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && bus_addr == ADDR_W'(OFF_FIFO) && level == '0)
        |-> (bus_rdata == 32'd0));

    p_fill_needs_seed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (ever_seeded || seed_valid));

    p_clr_int_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[CMD_CLR_INT] && !bus_wdata[CMD_CLR_ERR] &&
         err_val != 4'd0 && !busy)
        |=> (err_val != 4'd0) && $stable(st_done) && $stable(seed_done));

    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && (bus_wdata[CMD_TEST] || bus_wdata[CMD_SEED]))
        |=> (!busy || op_kind == $past(op_kind)));
endmodule

bind rng_ctl_top rng_ctl_chk #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .level     (fifo_level),
    .push      (gen_push),
    .seed_valid(seed_valid),
    .busy      (busy),
    .op_kind   (op_kind),
    .st_done   (st_done),
    .seed_done (seed_done),
    .err_val   (err_val)
);

// File: tb/tb_rng_ctl_top.sv
// Bench: scoreboard of random words plus directed register scenarios.
module tb_rng_ctl_top;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [3:0]        inj_err_code = 4'd0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model_x = 32'h1ACE_B00C;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    rng_ctl_top #(
        .ADDR_W       (ADDR_W),
        .OP_LAT       (6),
        .RESEED_BLOCKS(2)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .inj_err_code(inj_err_code),
        .irq         (irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver side of the scoreboard: queue the next n model words.
    task automatic expect_words(input int n);
        for (int i = 0; i < n; i++) begin
            model_x = {model_x[30:0], model_x[31] ^ model_x[21] ^ model_x[1] ^ model_x[0]};
            exp_q.push_back(model_x);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(addr);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic drain(input int n);
        logic [31:0] d;
        expect_words(n);
        for (int i = 0; i < n; i++) rd('h14, d);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor side of the scoreboard: compare every queue read.
    always @(negedge clk) begin
        #2;
        if (bus_en && !bus_we && bus_addr == ADDR_W'('h14) && exp_q.size() > 0) begin
            logic [31:0] e;
            e = exp_q.pop_front();
            check(bus_rdata == e, "R5 queue word order", bus_rdata, e);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd('h00, d); check(d == 32'h2000_0103, "R1 version", d, 32'h2000_0103);
        rd('h08, d); check(d == 0, "R1 control", d, 0);
        rd('h0C, d); check(d == 0, "R1 status", d, 0);
        rd('h10, d); check(d == 0, "R1 error", d, 0);
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 0);
        // R6 empty read
        rd('h14, d); check(d == 0, "R6 empty read", d, 0);
        rd('h0C, d); check(d[12:8] == 0, "R6 level after empty read", d[12:8], 0);
        // R7 no fill before seed
        idle(30);
        rd('h0C, d); check(d[12:8] == 0, "R7 no fill unseeded", d[12:8], 0);

        // R3 self test, R2 command reads zero
        wr('h04, 32'h1);
        rd('h04, d); check(d == 0, "R2 command reads zero", d, 0);
        idle(20);
        rd('h0C, d); check(d[4] == 1 && d[5] == 0, "R3 self test done", d, 32'h10);
        check(irq == 1'b1, "R10 irq on done", {31'd0, irq}, 1);
        wr('h04, 32'h10);
        rd('h0C, d); check(d[4] == 0, "R9 clear int no error", d, 0);
        check(irq == 1'b0, "R10 irq cleared", {31'd0, irq}, 0);

        // R11 start while busy ignored, R4 seed and fill
        wr('h04, 32'h2);
        wr('h04, 32'h1);
        idle(20);
        rd('h0C, d); check(d[5] == 1 && d[4] == 0, "R11 busy start ignored", d, 32'h20);
        idle(40);
        rd('h0C, d); check(d[12:8] == 15, "R4 idle fill 15", d[12:8], 15);
        drain(1);
        idle(5);
        rd('h0C, d); check(d[12:8] == 14, "R4 no group without room", d[12:8], 14);
        drain(3);
        idle(20);
        rd('h0C, d); check(d[12:8] == 16, "R4 fill to 16", d[12:8], 16);

        // R10 masks, R8 injected error
        wr('h08, 32'h20);
        wr('h04, 32'h10);
        check(irq == 1'b0, "R10 done masked", {31'd0, irq}, 0);
        inj_err_code = 4'h8;
        wr('h04, 32'h2);
        idle(20);
        inj_err_code = 4'h0;
        rd('h10, d); check(d == 8, "R8 error code", d, 8);
        rd('h0C, d); check(d[16] == 1 && d[5] == 1, "R8 error and done status", d, 32'h10020);
        check(irq == 1'b1, "R10 error unmasked", {31'd0, irq}, 1);
        wr('h08, 32'h60);
        check(irq == 1'b0, "R10 both masked", {31'd0, irq}, 0);
        wr('h08, 32'h40);
        check(irq == 1'b1, "R10 done unmasked only", {31'd0, irq}, 1);
        wr('h04, 32'h10);
        rd('h0C, d); check(d[16] == 1 && d[5] == 1, "R9 clear int blocked by error", d, 32'h10020);
        // R7 failed seed stops generation
        drain(16);
        idle(30);
        rd('h0C, d); check(d[12:8] == 0, "R7 failed seed no refill", d[12:8], 0);
        wr('h04, 32'h20);
        rd('h10, d); check(d == 0, "R9 clear error register", d, 0);
        rd('h0C, d); check(d[16] == 0 && d[5] == 0, "R9 clear error flags", d, 0);
        check(irq == 1'b0, "R9 irq after clear error", {31'd0, irq}, 0);

        // R13 retry seed
        wr('h08, 32'h0);
        wr('h04, 32'h2);
        idle(20);
        rd('h0C, d); check(d[5] == 1 && d[16] == 0, "R13 retry seed done", d, 32'h20);
        wr('h04, 32'h20);
        rd('h0C, d); check(d[5] == 1, "R9 clear error ignored without error", d, 32'h20);
        wr('h04, 32'h10);

        // R12 automatic reseeding
        idle(40);
        rd('h0C, d); check(d[5] == 0 && d[12:8] == 15, "R12 no reseed when disabled", d, 32'hF00);
        wr('h08, 32'h10);
        idle(20);
        rd('h0C, d); check(d[5] == 1, "R12 auto reseed done", d, 32'h20);
        check(irq == 1'b1, "R12 irq on auto reseed", {31'd0, irq}, 1);
        wr('h04, 32'h10);
        drain(15);
        idle(60);
        rd('h0C, d); check(d[5] == 1, "R12 second auto reseed", d, 32'h20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule